// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes a left/right pair of 16-bit PCM samples from an audio processing pipeline and shifts it out, one bit per bit-clock period, on the single data line of an external stereo DAC. A frame holds two 32-period slots: the left channel comes first with word select low, then the right channel with word select high. Each sample goes out most significant bit first in the upper part of its slot, and the remaining periods of the slot carry zeros.

The block does not generate the bit clock. A divider shared with the receive path runs from the master clock and gives the block a one-cycle strobe for each falling edge of the bit clock. Both outputs change only in the master-clock cycle that follows such a strobe. The DAC samples on the rising edge, so each bit is stable for the whole half period before the DAC captures it.

A load strobe places a new pair in a holding register. That register is copied into the shift path only when a new left slot begins, so a frame never mixes two pairs. If no new pair has arrived by that point, the previous pair is sent again.

Top module: `stx_serializer`

## Requirements
- R1: `sdata` and `wsel` change only in the master-clock cycle after a cycle in which `bit_fall` is high. At all other times both outputs hold their value.
- R2: A frame is 64 bit periods long. `wsel` is 0 for the first 32 periods (left slot) and 1 for the last 32 (right slot). It changes on the same strobe as the first bit of its slot.
- R3: Each 16-bit sample is sent MSB first in the first 16 periods of its slot. The left sample goes in the left slot and the right sample in the right slot.
- R4: Periods 16 to 31 of every slot (counted from 0 within the slot) carry a 0 on `sdata`.
- R5: A `load` pulse captures `left_in`/`right_in` into the holding register. A frame already in progress goes on sending its own pair, and the new pair starts at the next frame.
- R6: A `load` in the same cycle as the strobe that starts a frame is used by that frame.
- R7: With no `load` between two frame starts, the next frame repeats the previous pair. With several loads, the most recent one wins.
- R8: While `rst_n` is low, `sdata` and `wsel` are 0 and the holding register is cleared. The first strobe after reset sends the MSB of the left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_fall | input | 1 | One-cycle strobe marking a falling edge of the bit clock |
| load | input | 1 | Capture strobe for a new sample pair |
| left_in | input | 16 | Left-channel sample, two's complement |
| right_in | input | 16 | Right-channel sample, two's complement |
| sdata | output | 1 | Serial data to the DAC |
| wsel | output | 1 | Word select, 0 for left and 1 for right (tied 0 when disabled by parameter) |

## Verification
The hardest case to reach from the ports is a `load` that lands in the middle of a frame, or in exactly the cycle of the frame-starting strobe. The bench produces the bit-clock strobes itself, so it controls where every load falls. It places loads at a fixed position inside a frame, on the first strobe of a frame, and as two back-to-back loads between frames. Reset is applied in the middle of a frame to show that the next strobe starts again at the top of a left slot.

// File: rtl/stx_pkg.sv
package stx_pkg;

   typedef enum logic {
      STX_SIDE_LEFT  = 1'b0,
      STX_SIDE_RIGHT = 1'b1
   } stx_side_e;

   // Width of a counter that must index a given number of positions.
   function automatic int stx_cnt_w(input int positions);
      return (positions < 2) ? 1 : $clog2(positions);
   endfunction

endpackage

// File: rtl/stx_hold.sv
module stx_hold #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   output logic [SAMPLE_W-1:0] launch_l,
   output logic [SAMPLE_W-1:0] launch_r
);

   logic [SAMPLE_W-1:0] held_l;
   logic [SAMPLE_W-1:0] held_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_l <= '0;
         held_r <= '0;
      end else if (load) begin
         held_l <= left_in;
         held_r <= right_in;
      end
   end

   // A capture that coincides with a frame start goes straight through.
   always_comb begin
      launch_l = load ? left_in  : held_l;
      launch_r = load ? right_in : held_r;
   end

endmodule

// File: rtl/stx_slot_counter.sv
module stx_slot_counter
   import stx_pkg::*;
#(
   parameter int SLOT_W = 32,
   localparam int FRAME_W = 2 * SLOT_W,
   localparam int CNT_W   = stx_cnt_w(FRAME_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_fall,
   output logic [CNT_W-1:0] pos,
   output logic             frame_start,
   output stx_side_e        side
);

   localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] RIGHT_POS = CNT_W'(SLOT_W);

   logic [CNT_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (bit_fall) begin
         if (pos_q == LAST_POS) begin
            pos_q <= '0;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   always_comb begin
      pos         = pos_q;
      frame_start = bit_fall && (pos_q == '0);
      side        = (pos_q >= RIGHT_POS) ? STX_SIDE_RIGHT : STX_SIDE_LEFT;
   end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 32,
   localparam int FRAME_W = 2 * SLOT_W,
   localparam int PAD_W   = SLOT_W - SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_fall,
   input  logic                frame_start,
   input  logic [SAMPLE_W-1:0] launch_l,
   input  logic [SAMPLE_W-1:0] launch_r,
   output logic                sdata
);

   logic [FRAME_W-1:0] frame_vec;
   logic [FRAME_W-1:0] sr_q;
   logic               sdata_q;

   generate
      if (PAD_W == 0) begin : g_no_pad
         assign frame_vec = {launch_l, launch_r};
      end else begin : g_pad
         localparam logic [PAD_W-1:0] ZERO_PAD = '0;
         assign frame_vec = {launch_l, ZERO_PAD, launch_r, ZERO_PAD};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdata_q <= 1'b0;
         sr_q    <= '0;
      end else if (bit_fall) begin
         if (frame_start) begin
            {sdata_q, sr_q} <= {frame_vec, 1'b0};
         end else begin
            {sdata_q, sr_q} <= {sr_q, 1'b0};
         end
      end
   end

   assign sdata = sdata_q;

endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
   import stx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 32,
   parameter bit HAS_WS   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_fall,
   input  logic                load,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   output logic                sdata,
   output logic                wsel
);

   localparam int FRAME_W = 2 * SLOT_W;
   localparam int CNT_W   = stx_cnt_w(FRAME_W);

   generate
      if (SAMPLE_W < 1) begin : g_bad_sample
         $error("stx_serializer: SAMPLE_W must be at least 1");
      end
      if (SAMPLE_W > SLOT_W) begin : g_bad_slot
         $error("stx_serializer: SAMPLE_W must not exceed SLOT_W");
      end
   endgenerate

   logic [SAMPLE_W-1:0] launch_l;
   logic [SAMPLE_W-1:0] launch_r;
   logic [CNT_W-1:0]    slot_pos;
   logic                frame_start;
   stx_side_e           side;

   stx_hold #(
      .SAMPLE_W (SAMPLE_W)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .left_in  (left_in),
      .right_in (right_in),
      .launch_l (launch_l),
      .launch_r (launch_r)
   );

   stx_slot_counter #(
      .SLOT_W (SLOT_W)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_fall    (bit_fall),
      .pos         (slot_pos),
      .frame_start (frame_start),
      .side        (side)
   );

   stx_shifter #(
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (SLOT_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_fall    (bit_fall),
      .frame_start (frame_start),
      .launch_l    (launch_l),
      .launch_r    (launch_r),
      .sdata       (sdata)
   );

   generate
      if (HAS_WS) begin : g_ws
         logic ws_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ws_q <= 1'b0;
            end else if (bit_fall) begin
               ws_q <= (side == STX_SIDE_RIGHT);
            end
         end
         assign wsel = ws_q;
      end else begin : g_no_ws
         assign wsel = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/stx_serializer_chk.sv
module stx_serializer_chk #(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 32,
   parameter int CNT_W    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bit_fall,
   input logic                load,
   input logic [SAMPLE_W-1:0] left_in,
   input logic                sdata,
   input logic                wsel,
   input logic [CNT_W-1:0]    pos
);

   // R1: outputs move only after a falling-edge strobe
   a_r1_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_fall |=> $stable(sdata) && $stable(wsel));

   // R2: left slot opens with word select low
   a_r2_ws_left_start: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_fall && pos == '0) |=> !wsel);

   // R2: right slot opens with word select high
   a_r2_ws_right_start: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_fall && int'(pos) == SLOT_W) |=> wsel);

   // R6: coincident capture supplies the first left bit
   a_r6_msb_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_fall && load && pos == '0) |=> sdata == $past(left_in[SAMPLE_W-1]));

   // R4: padding periods are zero
   a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_fall && (int'(pos) % SLOT_W) >= SAMPLE_W) |=> !sdata);

   // R8: reset drives both lines low
   a_r8_reset_low: assert property (@(posedge clk)
      !rst_n |=> !sdata && !wsel);

endmodule

bind stx_serializer stx_serializer_chk #(
   .SAMPLE_W (SAMPLE_W),
   .SLOT_W   (SLOT_W),
   .CNT_W    (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_fall (bit_fall),
   .load     (load),
   .left_in  (left_in),
   .sdata    (sdata),
   .wsel     (wsel),
   .pos      (slot_pos)
);

// File: tb/stx_serializer_bench.sv
module stx_serializer_bench;

   localparam int SW = 16;
   localparam int SL = 32;
   localparam int FW = 2 * SL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_fall = 1'b0;
   logic          load = 1'b0;
   logic [SW-1:0] left_in = '0;
   logic [SW-1:0] right_in = '0;
   logic          sdata;
   logic          wsel;

   stx_serializer #(.SAMPLE_W(SW), .SLOT_W(SL), .HAS_WS(1'b1)) u_stx_serializer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_fall (bit_fall),
      .load     (load),
      .left_in  (left_in),
      .right_in (right_in),
      .sdata    (sdata),
      .wsel     (wsel)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [SW-1:0] m_hold_l = '0, m_hold_r = '0, m_cur_l = '0, m_cur_r = '0;
   int            m_pos = 0;
   logic          last_d = 1'b0, last_w = 1'b0;

   task automatic check(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b (frame pos %0d)", tag, what, act, exp, m_pos);
      end
   endtask

   task automatic strobe(input string tag, input logic ld, input logic [SW-1:0] l, input logic [SW-1:0] r);
      int slot;
      int idx;
      logic [SW-1:0] v;
      logic eb;
      @(negedge clk);
      bit_fall = 1'b1; load = ld; left_in = l; right_in = r;
      @(negedge clk);
      bit_fall = 1'b0; load = 1'b0;
      if (m_pos == 0) begin
         m_cur_l = ld ? l : m_hold_l;
         m_cur_r = ld ? r : m_hold_r;
      end
      if (ld) begin
         m_hold_l = l; m_hold_r = r;
      end
      slot = m_pos / SL;
      idx  = m_pos % SL;
      v    = (slot != 0) ? m_cur_r : m_cur_l;
      eb   = (idx < SW) ? v[SW-1-idx] : 1'b0;
      check((idx < SW) ? tag : "R4", sdata, eb, "data bit");
      check("R2", wsel, (slot != 0), "word select");
      last_d = eb; last_w = (slot != 0);
      m_pos = (m_pos + 1) % FW;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R1", sdata, last_d, "data held between strobes");
         check("R1", wsel, last_w, "word select held between strobes");
      end
   endtask

   task automatic load_only(input logic [SW-1:0] l, input logic [SW-1:0] r);
      @(negedge clk);
      load = 1'b1; left_in = l; right_in = r;
      @(negedge clk);
      load = 1'b0;
      m_hold_l = l; m_hold_r = r;
      check("R5", sdata, last_d, "data unchanged by load");
   endtask

   task automatic send_frame(input string tag, input logic ld, input logic [SW-1:0] l,
                             input logic [SW-1:0] r, input logic mid,
                             input logic [SW-1:0] ml, input logic [SW-1:0] mr);
      for (int p = 0; p < FW; p++) begin
         strobe(tag, (p == 0) && ld, l, r);
         if (mid && p == 10) load_only(ml, mr);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8", sdata, 1'b0, "data in reset");
      check("R8", wsel, 1'b0, "word select in reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R8: cleared holding register yields a silent first frame
      send_frame("R8", 1'b0, '0, '0, 1'b0, '0, '0);
      // R3: loaded pair shifted MSB first
      load_only(16'hA5C3, 16'h1234);
      send_frame("R3", 1'b0, '0, '0, 1'b0, '0, '0);
      // R7: no load repeats the pair
      send_frame("R7", 1'b0, '0, '0, 1'b0, '0, '0);
      // R7: latest of two loads wins
      load_only(16'h0F0F, 16'hF0F0);
      load_only(16'h8001, 16'h7FFE);
      send_frame("R7", 1'b0, '0, '0, 1'b0, '0, '0);
      // R5: mid-frame load does not split the frame, appears next frame
      send_frame("R5", 1'b0, '0, '0, 1'b1, 16'hFFFF, 16'h0000);
      send_frame("R5", 1'b0, '0, '0, 1'b0, '0, '0);
      // R6: load coincident with frame start
      send_frame("R6", 1'b1, 16'h3C69, 16'hC396, 1'b0, '0, '0);
      // R3: walking-one sweep over every bit position
      for (int i = 0; i < SW; i++) begin
         send_frame("R3", 1'b1, SW'(1) << i, ~(SW'(1) << i), 1'b0, '0, '0);
      end
      // R8: reset in the middle of a frame realigns to the left slot
      for (int p = 0; p < 20; p++) strobe("R3", 1'b0, '0, '0);
      @(negedge clk);
      rst_n = 1'b0;
      m_pos = 0; m_hold_l = '0; m_hold_r = '0; m_cur_l = '0; m_cur_r = '0;
      @(negedge clk);
      check("R8", sdata, 1'b0, "data after mid-frame reset");
      check("R8", wsel, 1'b0, "word select after mid-frame reset");
      rst_n = 1'b1;
      send_frame("R8", 1'b1, 16'hB00B, 16'h5EED, 1'b0, '0, '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule